// File: doc/BRIEF.md
# Fuse-Derived Serial Number CRC Engine

This block builds a 64-bit device serial number out of sixteen bytes held in a 32-byte fuse shadow store. It walks the store in a fixed interleaved order and reads one byte per clock over a synchronous read port. Each byte goes through a single-cycle, fully unrolled byte update of a reflected CRC-32. The first eight bytes give the low serial word. The CRC state is not cleared between the two passes, so the second eight bytes are folded on top of the low word and give the high word.

A single-cycle start pulse launches the computation. The two words and a valid flag stay registered until the next start pulse. A start pulse always clears the outputs and restarts the walk from the first stream byte, even when it arrives in the middle of a computation.

Top module: `fuse_serial_crc`

## Requirements
- R1: Stream byte i (i = 0..7) is read from shadow address 8+2i, and stream byte 8+i is read from shadow address 7+2i. During a walk, rd_addr therefore stays within 7..22.
- R2: serial_lo is the reflected CRC-32 (polynomial 0xEDB88320, data bits taken LSB first) of stream bytes 0..7. It starts from a seed of zero and has no final inversion.
- R3: serial_hi is the same CRC over stream bytes 8..15, with serial_lo as its seed.
- R4: The shadow store is read synchronously. The byte at rd_addr is expected on rd_data after the next rising clock edge.
- R5: serial_valid is first seen high 18 clock edges after the edge that samples start. At 17 edges it is still low.
- R6: Once serial_valid is high, it stays high and both words hold their values until the next start pulse.
- R7: The edge that samples start drives serial_valid, serial_lo and serial_hi to zero.
- R8: A start pulse during a computation discards that computation. The result then matches the shadow contents and timing of the new start.
- R9: Shadow bytes at addresses 0..6 and 23..31 have no effect on either word.
- R10: After reset, serial_valid, serial_lo and serial_hi are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle launch pulse |
| rd_addr | output | 5 | Shadow store read address |
| rd_data | input | 8 | Shadow store read data, one cycle after rd_addr |
| serial_lo | output | 32 | Low serial word |
| serial_hi | output | 32 | High serial word |
| serial_valid | output | 1 | Both serial words are final |

## Verification
Clearing takes effect on the edge that samples start, so the bench checks the zeroed outputs right after that edge. The result lands 18 edges after that same edge. The bench steps on falling edges, checks that serial_valid is still low after edge 17 and high after edge 18, and compares both words only at that point. Hold behaviour is checked 12 cycles later, with no new start in between. The checker module counts cycles from start and ties the rising edge of serial_valid to that exact count.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // One byte through a reflected CRC, unrolled over its eight bits.
  function automatic logic [31:0] crc_byte(input logic [31:0] state,
                                           input logic [7:0]  data,
                                           input logic [31:0] poly);
    logic [31:0] r;
    r = state ^ {24'h0, data};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/fsc_gather.sv
module fsc_gather #(
  parameter int AW        = 5,
  parameter int PASS_LEN  = 8,
  parameter int EVEN_BASE = 8,
  parameter int ODD_BASE  = 7,
  localparam int SLEN     = 2 * PASS_LEN,
  localparam int IW       = $clog2(SLEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] rd_addr,
  output logic          issue,
  output logic          tag_vld,
  output logic [IW-1:0] tag_idx
);
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue <= 1'b0;
      idx   <= '0;
    end else if (start) begin
      issue <= 1'b1;
      idx   <= '0;
    end else if (issue) begin
      if (idx == IW'(SLEN - 1)) issue <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  // Interleaved walk: first pass on one parity, second pass on the other.
  always_comb begin
    logic [AW-1:0] iw;
    iw = AW'(idx);
    if (idx < IW'(PASS_LEN))
      rd_addr = AW'(EVEN_BASE) + (iw << 1);
    else
      rd_addr = AW'(ODD_BASE) + ((iw - AW'(PASS_LEN)) << 1);
  end

  // Tag that travels alongside the synchronous read.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_vld <= 1'b0;
      tag_idx <= '0;
    end else begin
      tag_vld <= issue & ~start;
      tag_idx <= idx;
    end
  end
endmodule

// File: rtl/fsc_crc_unit.sv
module fsc_crc_unit #(
  parameter int          PASS_LEN = 8,
  parameter logic [31:0] POLY     = fsc_pkg::CRC_POLY_REFL,
  localparam int         SLEN     = 2 * PASS_LEN,
  localparam int         IW       = $clog2(SLEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          tag_vld,
  input  logic [IW-1:0] tag_idx,
  input  logic [7:0]    data,
  output logic [31:0]   word_lo,
  output logic [31:0]   word_hi,
  output logic          valid
);
  logic [31:0] acc;
  logic [31:0] nxt;
  logic        done;

  assign nxt = fsc_pkg::crc_byte(acc, data, POLY);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      acc     <= '0;
      word_lo <= '0;
      word_hi <= '0;
      valid   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tag_vld) begin
        acc <= nxt;  // state carries over: second pass seeded by first
        if (tag_idx == IW'(PASS_LEN - 1)) word_lo <= nxt;
        if (tag_idx == IW'(SLEN - 1)) begin
          word_hi <= nxt;
          done    <= 1'b1;
        end
      end
      if (done) valid <= 1'b1;
    end
  end
endmodule

// File: rtl/fuse_serial_crc.sv
module fuse_serial_crc #(
  parameter int          SHADOW_BYTES = 32,
  parameter int          PASS_LEN     = 8,
  parameter int          EVEN_BASE    = 8,
  parameter int          ODD_BASE     = 7,
  parameter logic [31:0] POLY         = fsc_pkg::CRC_POLY_REFL,
  localparam int         AW           = $clog2(SHADOW_BYTES),
  localparam int         IW           = $clog2(2 * PASS_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic [31:0]   serial_lo,
  output logic [31:0]   serial_hi,
  output logic          serial_valid
);
  logic          issue;
  logic          tag_vld;
  logic [IW-1:0] tag_idx;

  fsc_gather #(
    .AW(AW), .PASS_LEN(PASS_LEN), .EVEN_BASE(EVEN_BASE), .ODD_BASE(ODD_BASE)
  ) u_gather (
    .clk(clk), .rst(rst), .start(start), .rd_addr(rd_addr),
    .issue(issue), .tag_vld(tag_vld), .tag_idx(tag_idx)
  );

  fsc_crc_unit #(.PASS_LEN(PASS_LEN), .POLY(POLY)) u_crc (
    .clk(clk), .rst(rst), .start(start), .tag_vld(tag_vld),
    .tag_idx(tag_idx), .data(rd_data), .word_lo(serial_lo),
    .word_hi(serial_hi), .valid(serial_valid)
  );
endmodule

// File: rtl/fsc_chk.sv
module fsc_chk #(
  parameter int AW        = 5,
  parameter int PASS_LEN  = 8,
  parameter int EVEN_BASE = 8,
  parameter int ODD_BASE  = 7,
  localparam int LAT      = 2 * PASS_LEN + 2,
  localparam int CW       = $clog2(LAT + 3) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          issue,
  input logic [AW-1:0] rd_addr,
  input logic          valid,
  input logic [31:0]   lo,
  input logic [31:0]   hi
);
  logic [CW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (start) since <= CW'(1);
    else if (since != '0 && since != {CW{1'b1}}) since <= since + 1'b1;
  end

  // R1
  addr_window_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> (rd_addr >= AW'(ODD_BASE) && rd_addr <= AW'(EVEN_BASE + 2 * (PASS_LEN - 1))));

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> since == CW'(LAT + 1));

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !start) |=> valid);

  // R6
  words_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !start) |=> ($stable(lo) && $stable(hi)));

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (!valid && lo == 32'h0 && hi == 32'h0));
endmodule

bind fuse_serial_crc fsc_chk #(
  .AW(AW), .PASS_LEN(PASS_LEN), .EVEN_BASE(EVEN_BASE), .ODD_BASE(ODD_BASE)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .issue(issue), .rd_addr(rd_addr),
  .valid(serial_valid), .lo(serial_lo), .hi(serial_hi)
);

// File: tb/tb_fuse_serial_crc.sv
module tb_fuse_serial_crc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [31:0] serial_lo, serial_hi;
  logic        serial_valid;
  logic [7:0]  shadow [32];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  fuse_serial_crc dut (
    .clk(clk), .rst(rst), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
    .serial_lo(serial_lo), .serial_hi(serial_hi), .serial_valid(serial_valid)
  );

  // R4: synchronous-read shadow store model
  always_ff @(posedge clk) rd_data <= shadow[rd_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bitwise reference: feedback bit = state LSB xor data bit.
  function automatic logic [31:0] ref_crc(input logic [31:0] seed, input int first);
    logic [31:0] c;
    logic fb;
    c = seed;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d;
      d = (first == 0) ? shadow[8 + 2 * k] : shadow[7 + 2 * k];
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ d[b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_check(input string tag);
    logic [31:0] elo, ehi;
    elo = ref_crc(32'h0, 0);
    ehi = ref_crc(elo, 1);
    pulse_start();
    chk({"R7 clear valid ", tag}, {31'h0, serial_valid}, 32'h0);
    chk({"R7 clear lo ", tag}, serial_lo, 32'h0);
    chk({"R7 clear hi ", tag}, serial_hi, 32'h0);
    repeat (17) @(negedge clk);
    chk({"R5 not yet valid ", tag}, {31'h0, serial_valid}, 32'h0);
    @(negedge clk);
    chk({"R5 valid ", tag}, {31'h0, serial_valid}, 32'h1);
    chk({"R1 R2 lo ", tag}, serial_lo, elo);
    chk({"R3 hi ", tag}, serial_hi, ehi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] slo, shi;
    for (int i = 0; i < 32; i++) shadow[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset valid", {31'h0, serial_valid}, 32'h0);
    chk("R10 reset lo", serial_lo, 32'h0);
    chk("R10 reset hi", serial_hi, 32'h0);

    run_check("zeros");
    for (int i = 0; i < 32; i++) shadow[i] = 8'hFF;
    run_check("ones");

    // R1: a single marked byte at every address exposes the gather order
    for (int p = 0; p < 32; p++) begin
      for (int i = 0; i < 32; i++) shadow[i] = 8'h0;
      shadow[p] = 8'hA5 ^ 8'(p);
      run_check($sformatf("R1 marker %0d", p));
    end

    // R6: hold until the next start
    slo = serial_lo; shi = serial_hi;
    repeat (12) @(negedge clk);
    chk("R6 valid held", {31'h0, serial_valid}, 32'h1);
    chk("R6 lo held", serial_lo, slo);
    chk("R6 hi held", serial_hi, shi);

    // R2 R3 R4: random shadow contents
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 32; i++) shadow[i] = 8'($urandom);
      run_check($sformatf("R4 random %0d", t));
    end

    // R9: unused bytes are ignored
    for (int i = 0; i < 32; i++) shadow[i] = 8'($urandom);
    run_check("R9 base");
    slo = serial_lo; shi = serial_hi;
    for (int i = 0; i < 7; i++) shadow[i] = ~shadow[i];
    for (int i = 23; i < 32; i++) shadow[i] = ~shadow[i];
    run_check("R9 scrambled");
    chk("R9 lo unaffected", serial_lo, slo);
    chk("R9 hi unaffected", serial_hi, shi);

    // R8: restart in mid-flight with new contents
    for (int i = 0; i < 32; i++) shadow[i] = 8'($urandom);
    pulse_start();
    repeat (6) @(negedge clk);
    for (int i = 0; i < 32; i++) shadow[i] = 8'($urandom);
    run_check("R8 restart");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule